// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one synchronisation cell that several hardware threads share. It holds a 16-bit count and a bitmask of threads that are parked on it. A requester presents one access per cycle on a strobe. The access carries a 4-bit view code that selects how the cell reacts, a direction, a thread number and write data. This view-code interface is the same one that the FIFO cells beside it decode. Taking the semaphore is a read in one of the two P/V views. Releasing it is a write in either P/V view, and the write data is ignored. A read in the raw view shows the count and changes nothing.

Every access gets exactly one response, one cycle after it is accepted. The response holds the read data and a stall flag. The request side has no back-pressure: the strobe is always accepted, and the only "not now" answer is the stall flag. When the count is zero, a blocking take stalls and the requester is recorded as a waiter. A polling take at zero answers 0 and leaves all state alone. A release that finds waiters raises a one-cycle wake pulse with one bit per parked thread, and it empties the mask. A woken thread issues its access again, and that access is judged from scratch with no memory of the earlier stall.

View codes: 0 = raw, 1 = control, 2 = blocking empty/full, 3 = polling empty/full, 4 = blocking P/V, 5 = polling P/V. Every other code is unused.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, no thread is waiting, and `rsp_valid`, `rsp_stall` and `wake` are all 0. A release issued straight after reset produces no wake pulse.
- R2: A read in view 4 or 5 with a non-zero count returns the count from before the access in `rsp_data` with `rsp_stall` = 0, and it lowers the count by one.
- R3: A read in view 4 with a count of 0 returns 0 with `rsp_stall` = 1, records the requesting thread as a waiter, and leaves the count at 0.
- R4: A read in view 5 with a count of 0 returns 0 with `rsp_stall` = 0, and it changes neither the count nor the waiter set.
- R5: A write in view 4 or 5 raises the count by one whatever its data. A count of 0xFFFF stays at 0xFFFF.
- R6: A write in view 4 or 5 drives `wake` in the response cycle with the bit of every waiting thread (bit n = thread n), and it clears all waiters. `wake` is 0 in every other cycle.
- R7: Writes in views 4 and 5 have the same effect on the count, the response and the wake pulse.
- R8: A read in view 0 returns the count unchanged. A write in view 0 changes nothing.
- R9: Views 1, 2, 3 and the unused codes never change the count or the waiters, and their reads return 0. In particular a control-view read shows bit 17, the FIFO-kind flag, as 0.
- R10: Every cycle with `req_valid` = 1 is followed by exactly one cycle with `rsp_valid` = 1, and no response appears without a request.
- R11: A thread that reissues its take after a wake is judged on the count at that moment: it succeeds if another thread has not already taken the unit, and otherwise it stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code of the access |
| req_tid | input | TID_W (3) | Requesting thread number |
| req_wdata | input | DATA_W (32) | Write data (never stored) |
| rsp_valid | output | 1 | Response present, one cycle after the access |
| rsp_data | output | DATA_W (32) | Read result, zero-extended count or 0 |
| rsp_stall | output | 1 | Blocking take found the count at 0 |
| wake | output | THREADS (8) | One-cycle pulse, one bit per thread woken |

## Verification
The bound checker watches the count and waiter mask on every cycle. It checks that a take lowers the count and answers with the old value, that a blocking take at zero stalls and parks the thread, and that a polling take at zero is inert. It also checks that a release saturates and turns the mask into the wake pulse, that the remaining views hold all state still, and that one response follows each access. Only the bench scenarios can show the ordered stories: two threads parked together and woken by one release, a woken thread winning or losing its retry (R11), the full climb from zero to saturation, and the wake pulse confirming after reset that no waiter survived.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
  // View codes shared with the neighbouring FIFO cells
  localparam logic [3:0] VIEW_RAW     = 4'd0;
  localparam logic [3:0] VIEW_CTRL    = 4'd1;
  localparam logic [3:0] VIEW_EF_WAIT = 4'd2;
  localparam logic [3:0] VIEW_EF_POLL = 4'd3;
  localparam logic [3:0] VIEW_PV_WAIT = 4'd4;
  localparam logic [3:0] VIEW_PV_POLL = 4'd5;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PEEK,
    OP_TAKE_WAIT,
    OP_TAKE_POLL,
    OP_GIVE
  } sem_op_e;
endpackage

// File: rtl/sem_cell_decode.sv
module sem_cell_decode
  import sem_cell_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [3:0] view_i,
  output sem_op_e    op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      unique case (view_i)
        VIEW_RAW:     op_o = write_i ? OP_NONE : OP_PEEK;
        VIEW_PV_WAIT: op_o = write_i ? OP_GIVE : OP_TAKE_WAIT;
        VIEW_PV_POLL: op_o = write_i ? OP_GIVE : OP_TAKE_POLL;
        default:      op_o = OP_NONE; // control, empty/full, unused
      endcase
    end
  end
endmodule

// File: rtl/sem_cell_count.sv
module sem_cell_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (give_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (take_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sem_cell_waitmask.sv
module sem_cell_waitmask #(
  parameter int THREADS = 8,
  parameter int TID_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               park_i,
  input  logic [TID_W-1:0]   tid_i,
  input  logic               release_i,
  output logic [THREADS-1:0] mask_o,
  output logic [THREADS-1:0] wake_o
);
  logic [THREADS-1:0] mask_q;
  logic [THREADS-1:0] wake_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[t] <= 1'b0;
        wake_q[t] <= 1'b0;
      end else begin
        wake_q[t] <= release_i & mask_q[t];
        if (release_i)
          mask_q[t] <= 1'b0;
        else if (park_i && tid_i == TID_W'(t))
          mask_q[t] <= 1'b1;
      end
    end
  end

  assign mask_o = mask_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [3:0]         req_view,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_stall,
  output logic [THREADS-1:0] wake
);
  sem_op_e            op;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_zero;
  logic [THREADS-1:0] wait_mask;
  logic               take, give, park;
  logic               shows_count;

  // release carries no payload
  logic unused_wdata;
  assign unused_wdata = ^req_wdata;

  sem_cell_decode u_decode (
    .valid_i (req_valid),
    .write_i (req_write),
    .view_i  (req_view),
    .op_o    (op)
  );

  assign take        = (op == OP_TAKE_WAIT) || (op == OP_TAKE_POLL);
  assign give        = (op == OP_GIVE);
  assign park        = (op == OP_TAKE_WAIT) && cnt_zero;
  assign shows_count = take || (op == OP_PEEK);

  sem_cell_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .give_i (give),
    .cnt_o  (cnt_q),
    .zero_o (cnt_zero)
  );

  sem_cell_waitmask #(.THREADS(THREADS), .TID_W(TID_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_i    (park),
    .tid_i     (req_tid),
    .release_i (give),
    .mask_o    (wait_mask),
    .wake_o    (wake)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_stall <= park;
      rsp_data  <= shows_count ? DATA_W'(cnt_q) : '0;
    end
  end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk
  import sem_cell_pkg::*;
#(
  parameter int THREADS = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int TID_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [3:0]         req_view,
  input logic [TID_W-1:0]   req_tid,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               rsp_stall,
  input logic [THREADS-1:0] wake,
  input logic [CNT_W-1:0]   cnt,
  input logic [THREADS-1:0] mask
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic pv_view, rd_pv, rd_wait0, rd_poll0, rel, quiet;
  logic [DATA_W-1:0] cnt_ext;
  assign pv_view  = (req_view == VIEW_PV_WAIT) || (req_view == VIEW_PV_POLL);
  assign rd_pv    = req_valid && !req_write && pv_view;
  assign rd_wait0 = req_valid && !req_write && req_view == VIEW_PV_WAIT && cnt == '0;
  assign rd_poll0 = req_valid && !req_write && req_view == VIEW_PV_POLL && cnt == '0;
  assign rel      = req_valid && req_write && pv_view;
  assign quiet    = req_valid && !pv_view;
  assign cnt_ext  = DATA_W'(cnt);

  p_one_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pv && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && (rsp_data == $past(cnt_ext)) && !rsp_stall);
  p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait0 |=> rsp_stall && (cnt == '0) && (rsp_data == '0) && mask[$past(req_tid)]);
  p_poll_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poll0 |=> !rsp_stall && (rsp_data == '0) && (cnt == '0) && $stable(mask));
  p_give_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && cnt == CMAX) |=> cnt == CMAX);
  p_wake_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (wake == $past(mask)) && (mask == '0));
  p_wake_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rel |=> wake == '0);
  p_other_views_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(cnt) && $stable(mask));
  p_raw_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !req_write && req_view == VIEW_RAW) |=> rsp_data == $past(cnt_ext));

  logic unused_chk;
  assign unused_chk = rsp_valid ^ ^rsp_data;
endmodule

bind sem_cell sem_cell_chk #(
  .THREADS(THREADS), .CNT_W(CNT_W), .DATA_W(DATA_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_view(req_view), .req_tid(req_tid), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_stall(rsp_stall), .wake(wake),
  .cnt(cnt_q), .mask(wait_mask)
);

// File: tb/sem_cell_test.sv
module sem_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic        w;
    logic [3:0]  view;
    logic [2:0]  tid;
    logic [31:0] wdata;
    logic [31:0] exp_data;
    logic        exp_stall;
    logic [7:0]  exp_wake;
  } vec_t;

  // Walk from reset; comments give the count after each step
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd5, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R4 poll at 0
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R8 raw read
    '{1'b1, 4'd4, 3'd1, 32'hDEAD_BEEF, 32'd0, 1'b0, 8'h00}, // R5 give -> 1
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd1, 1'b0, 8'h00}, // R5
    '{1'b1, 4'd5, 3'd2, 32'h0,        32'd0, 1'b0, 8'h00}, // R7 poll give -> 2
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd2, 1'b0, 8'h00}, // R7
    '{1'b1, 4'd0, 3'd0, 32'h55,       32'd0, 1'b0, 8'h00}, // R8 raw write
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd2, 1'b0, 8'h00}, // R8 unchanged
    '{1'b0, 4'd4, 3'd0, 32'h0,        32'd2, 1'b0, 8'h00}, // R2 -> 1
    '{1'b0, 4'd5, 3'd1, 32'h0,        32'd1, 1'b0, 8'h00}, // R2 -> 0
    '{1'b0, 4'd4, 3'd3, 32'h0,        32'd0, 1'b1, 8'h00}, // R3 park t3
    '{1'b0, 4'd4, 3'd5, 32'h0,        32'd0, 1'b1, 8'h00}, // R3 park t5
    '{1'b1, 4'd2, 3'd0, 32'h7,        32'd0, 1'b0, 8'h00}, // R9 ef write
    '{1'b0, 4'd3, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R9 ef read
    '{1'b0, 4'd1, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R9 control read
    '{1'b1, 4'd1, 3'd0, 32'h1,        32'd0, 1'b0, 8'h00}, // R9 control write
    '{1'b1, 4'd9, 3'd0, 32'h3,        32'd0, 1'b0, 8'h00}, // R9 unused view
    '{1'b0, 4'd9, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R9
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R9 still 0
    '{1'b1, 4'd5, 3'd0, 32'h0,        32'd0, 1'b0, 8'h28}, // R6 wake t3,t5 -> 1
    '{1'b0, 4'd4, 3'd3, 32'h0,        32'd1, 1'b0, 8'h00}, // R11 t3 wins -> 0
    '{1'b0, 4'd4, 3'd5, 32'h0,        32'd0, 1'b1, 8'h00}, // R11 t5 parks again
    '{1'b1, 4'd4, 3'd0, 32'h0,        32'd0, 1'b0, 8'h20}, // R6 wake t5 -> 1
    '{1'b0, 4'd4, 3'd5, 32'h0,        32'd1, 1'b0, 8'h00}, // R11 t5 wins -> 0
    '{1'b1, 4'd4, 3'd0, 32'h0,        32'd0, 1'b0, 8'h00}, // R6 no waiters -> 1
    '{1'b0, 4'd0, 3'd0, 32'h0,        32'd1, 1'b0, 8'h00}  // R5 count 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_view = 4'd0;
  logic [2:0]  req_tid = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_stall;
  logic [7:0]  wake;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_cell uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_stall(rsp_stall),
    .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access, then the response is sampled on the following negedge
  task automatic access(input logic w, input logic [3:0] v, input logic [2:0] t,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic st, output logic [7:0] wk);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_view = v; req_tid = t; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R10 response", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_data; st = rsp_stall; wk = wake;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        st;
    logic [7:0]  wk;

    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && wake === 8'h00, "R1 reset outputs",
        {23'd0, rsp_valid, wake}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 idle", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].w, TBL[i].view, TBL[i].tid, TBL[i].wdata, rd, st, wk);
      chk(rd === TBL[i].exp_data, $sformatf("R2-table data step %0d", i), rd, TBL[i].exp_data);
      chk(st === TBL[i].exp_stall, $sformatf("R3 stall step %0d", i), {31'd0, st}, {31'd0, TBL[i].exp_stall});
      chk(wk === TBL[i].exp_wake, $sformatf("R6 wake step %0d", i), {24'd0, wk}, {24'd0, TBL[i].exp_wake});
    end

    // R1: park a thread, reset, then a release must wake nobody
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);   // count 1
    access(1'b0, 4'd5, 3'd0, 32'h0, rd, st, wk);   // -> 0
    access(1'b0, 4'd4, 3'd2, 32'h0, rd, st, wk);
    chk(st === 1'b1, "R3 park t2", {31'd0, st}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_stall === 1'b0 && wake === 8'h00, "R1 reset clears",
        {22'd0, rsp_valid, rsp_stall, wake}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);
    chk(rd === 32'd0, "R1 count zero", rd, 32'd0);
    access(1'b1, 4'd5, 3'd0, 32'h0, rd, st, wk);   // -> 1
    chk(wk === 8'h00, "R1 no waiter survives", {24'd0, wk}, 32'd0);

    // R5 saturation: back-to-back releases to 0xFFFE
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_view = 4'd4; req_wdata = 32'h0;
    repeat (65533) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);
    chk(rd === 32'h0000_FFFE, "R5 climb", rd, 32'h0000_FFFE);
    access(1'b1, 4'd5, 3'd0, 32'h0, rd, st, wk);
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);
    chk(rd === 32'h0000_FFFF, "R5 reach max", rd, 32'h0000_FFFF);
    access(1'b1, 4'd4, 3'd0, 32'hFFFF_FFFF, rd, st, wk);
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);
    chk(rd === 32'h0000_FFFF, "R5 saturate", rd, 32'h0000_FFFF);
    access(1'b0, 4'd5, 3'd4, 32'h0, rd, st, wk);
    chk(rd === 32'h0000_FFFF && st === 1'b0, "R2 take at max", rd, 32'h0000_FFFF);
    access(1'b0, 4'd0, 3'd0, 32'h0, rd, st, wk);
    chk(rd === 32'h0000_FFFE, "R2 decremented", rd, 32'h0000_FFFE);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule